// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This unit sits inside a hart and holds the timer comparison state for the supervisor and the guest (virtual-supervisor) levels. It keeps a local copy of the platform time value, delayed by a short synchronizer pipeline. It also holds two 64-bit compare registers: one for the supervisor and one for the guest. From these it drives two level-sensitive timer-pending lines.

The guest comparison adds a per-guest offset to the local time. The offset is added to the un-offset local value once, and the sum wraps modulo 2^64. All comparisons are unsigned.

A single-cycle CSR port reads and writes the compare registers and reads the time value. Each access is decided in the same cycle. It is either permitted or reported as an illegal-instruction trap or a virtual-instruction trap. When a guest accesses the supervisor compare address, the access is redirected to the guest compare register. This lets an unmodified guest kernel program its own timer.

Top module: `timer_compare_unit`

## Requirements
- R1: The local time resets to 0 and equals the platform time input as it stood SYNC_STAGES (default 2) clock edges earlier. A read of the time address (0xC01) outside guest context returns it.
- R2: supPending is high exactly when local time >= supervisor compare, with both values taken as unsigned.
- R3: guestPending is high exactly when (local time + guestOffset) mod 2^64 >= guest compare, with the comparison unsigned.
- R4: Both compare registers reset to all ones, so both pending lines are low after reset.
- R5: A permitted write updates the target register at the clock edge. The pending line reflects the new value in the very next cycle.
- R6: In a guest with S privilege (priv=01, virt=1), machTimerEn=1, hypTimerEn=1 and cmpEnable=1, accesses to the supervisor compare address (0x14D) read and write the guest compare register.
- R7: Any access to the guest compare address (0x24D) with virt=1 and priv not M raises trapVirtual.
- R8: An access to 0x14D from S or guest context with machTimerEn=0 raises trapIllegal. M-mode (priv=11) access to 0x14D and 0x24D is always permitted.
- R9: A guest access to 0x14D with machTimerEn=1 and hypTimerEn=0 raises trapIllegal.
- R10: A non-M access to 0x14D with cmpEnable=0 raises trapIllegal.
- R11: Any write to the time address raises trapIllegal. A guest read of the time address returns local time + guestOffset.
- R12: At most one trap line is high. A trapped access returns read data 0 and changes no register.
- R13: U-mode (priv=00, virt=0) access to 0x14D or 0x24D raises trapIllegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| platformTime | input | 64 | Platform time value |
| guestOffset | input | 64 | Offset added to time for the guest |
| machTimerEn | input | 1 | Machine-level timer counter enable |
| hypTimerEn | input | 1 | Hypervisor-level timer counter enable |
| cmpEnable | input | 1 | Enables the supervisor-level compare facility |
| priv | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| virt | input | 1 | Virtualization (guest) flag |
| csrValid | input | 1 | CSR access this cycle |
| csrWrite | input | 1 | Access is a write |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Read data, 0 when trapped or unmapped |
| trapIllegal | output | 1 | Illegal-instruction trap |
| trapVirtual | output | 1 | Virtual-instruction trap |
| supPending | output | 1 | Supervisor timer pending |
| guestPending | output | 1 | Guest timer pending |

## Verification
A corrupted compare register or time stage is not hidden. The pending lines are combinational from that state, so the fault shows on them in the same cycle. It also shows on the read data of the next M-mode access to that register.

A wrong redirect or permission decision shows on the trap lines within the access cycle. A write that should have been dropped changes the register, and that change shows on a pending line one cycle after the write.

The reference model is therefore compared against all five outputs on every clock. It runs across time crossings, offset wrap-around and every privilege and enable combination named in the requirements.

// File: rtl/timer_compare_pkg.sv
package timer_compare_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } privMode_t;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic rdSup;
    logic rdGuest;
    logic rdTime;
    logic rdTimeOff;
    logic wrSup;
    logic wrGuest;
  } cmpStrobe_t;

endpackage

// File: rtl/timer_compare_ctrl.sv
module timer_compare_ctrl
  import timer_compare_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_SUP = 12'h14D,
  parameter logic [ADDR_W-1:0] ADDR_GUEST = 12'h24D,
  parameter logic [ADDR_W-1:0] ADDR_TIME = 12'hC01
) (
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              machTimerEn,
  input  logic              hypTimerEn,
  input  logic              cmpEnable,
  input  logic              csrValid,
  input  logic              csrWrite,
  input  logic [ADDR_W-1:0] csrAddr,
  output cmpStrobe_t        strobe,
  output logic              trapIllegal,
  output logic              trapVirtual
);

  privMode_t mode;
  logic isM;
  logic isS;
  logic inGuest;

  assign mode    = privMode_t'(priv);
  assign isM     = (mode == PRIV_M);
  assign isS     = (mode == PRIV_S);
  assign inGuest = virt && !isM;

  always_comb begin
    strobe      = '0;
    trapIllegal = 1'b0;
    trapVirtual = 1'b0;
    if (csrValid) begin
      if (csrAddr == ADDR_TIME) begin
        if (csrWrite) begin
          trapIllegal = 1'b1;
        end else if (inGuest) begin
          strobe.rdTimeOff = 1'b1;
        end else begin
          strobe.rdTime = 1'b1;
        end
      end else if (csrAddr == ADDR_SUP) begin
        if (isM) begin
          strobe.rdSup = 1'b1;
          strobe.wrSup = csrWrite;
        end else if (!isS || !machTimerEn || !cmpEnable) begin
          trapIllegal = 1'b1;
        end else if (virt) begin
          if (!hypTimerEn) begin
            trapIllegal = 1'b1;
          end else begin
            strobe.rdGuest = 1'b1;
            strobe.wrGuest = csrWrite;
          end
        end else begin
          strobe.rdSup = 1'b1;
          strobe.wrSup = csrWrite;
        end
      end else if (csrAddr == ADDR_GUEST) begin
        if (inGuest) begin
          trapVirtual = 1'b1;
        end else if (isM || isS) begin
          strobe.rdGuest = 1'b1;
          strobe.wrGuest = csrWrite;
        end else begin
          trapIllegal = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/timer_compare_datapath.sv
module timer_compare_datapath
  import timer_compare_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] platformTime,
  input  logic [TIME_W-1:0] guestOffset,
  input  logic [TIME_W-1:0] csrWdata,
  input  cmpStrobe_t        strobe,
  output logic [TIME_W-1:0] csrRdata,
  output logic              supPending,
  output logic              guestPending
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [TIME_W-1:0] timeStage [SYNC_STAGES];
  logic [TIME_W-1:0] localTime;
  logic [TIME_W-1:0] guestTime;
  logic [TIME_W-1:0] supCmp;
  logic [TIME_W-1:0] guestCmp;

  always_ff @(posedge clk) begin
    if (!rstN) timeStage[0] <= '0;
    else       timeStage[0] <= platformTime;
  end

  for (genvar gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) timeStage[gi] <= '0;
      else       timeStage[gi] <= timeStage[gi-1];
    end
  end

  assign localTime = timeStage[LAST];
  assign guestTime = localTime + guestOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supCmp   <= '1;
      guestCmp <= '1;
    end else begin
      if (strobe.wrSup)   supCmp   <= csrWdata;
      if (strobe.wrGuest) guestCmp <= csrWdata;
    end
  end

  always_comb begin
    csrRdata = '0;
    if (strobe.rdSup)     csrRdata = csrRdata | supCmp;
    if (strobe.rdGuest)   csrRdata = csrRdata | guestCmp;
    if (strobe.rdTime)    csrRdata = csrRdata | localTime;
    if (strobe.rdTimeOff) csrRdata = csrRdata | guestTime;
  end

  assign supPending   = (localTime >= supCmp);
  assign guestPending = (guestTime >= guestCmp);

endmodule

// File: rtl/timer_compare_unit.sv
module timer_compare_unit
  import timer_compare_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_SUP = 12'h14D,
  parameter logic [ADDR_W-1:0] ADDR_GUEST = 12'h24D,
  parameter logic [ADDR_W-1:0] ADDR_TIME = 12'hC01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] platformTime,
  input  logic [TIME_W-1:0] guestOffset,
  input  logic              machTimerEn,
  input  logic              hypTimerEn,
  input  logic              cmpEnable,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              csrValid,
  input  logic              csrWrite,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [TIME_W-1:0] csrWdata,
  output logic [TIME_W-1:0] csrRdata,
  output logic              trapIllegal,
  output logic              trapVirtual,
  output logic              supPending,
  output logic              guestPending
);

  cmpStrobe_t strobe;

  timer_compare_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_SUP(ADDR_SUP),
    .ADDR_GUEST(ADDR_GUEST), .ADDR_TIME(ADDR_TIME)
  ) u_ctrl (
    .priv(priv), .virt(virt), .machTimerEn(machTimerEn),
    .hypTimerEn(hypTimerEn), .cmpEnable(cmpEnable),
    .csrValid(csrValid), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .strobe(strobe), .trapIllegal(trapIllegal), .trapVirtual(trapVirtual)
  );

  timer_compare_datapath #(
    .TIME_W(TIME_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .platformTime(platformTime),
    .guestOffset(guestOffset), .csrWdata(csrWdata), .strobe(strobe),
    .csrRdata(csrRdata), .supPending(supPending), .guestPending(guestPending)
  );

endmodule

// File: rtl/timer_compare_unit_chk.sv
module timer_compare_unit_chk #(
  parameter int TIME_W = 64,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_SUP = 12'h14D,
  parameter logic [ADDR_W-1:0] ADDR_GUEST = 12'h24D,
  parameter logic [ADDR_W-1:0] ADDR_TIME = 12'hC01
) (
  input logic              clk,
  input logic              rstN,
  input logic              machTimerEn,
  input logic [1:0]        priv,
  input logic              virt,
  input logic              csrValid,
  input logic              csrWrite,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [TIME_W-1:0] csrRdata,
  input logic              trapIllegal,
  input logic              trapVirtual
);

  assert_one_trap_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(trapIllegal && trapVirtual));

  assert_trap_zero_data_R12: assert property (@(posedge clk) disable iff (!rstN)
    (trapIllegal || trapVirtual) |-> (csrRdata == '0));

  assert_guest_direct_R7: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrAddr == ADDR_GUEST && virt && priv != 2'b11) |-> trapVirtual);

  assert_machine_access_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && priv == 2'b11 && (csrAddr == ADDR_SUP || csrAddr == ADDR_GUEST))
      |-> (!trapIllegal && !trapVirtual));

  assert_mach_en_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrAddr == ADDR_SUP && priv != 2'b11 && !machTimerEn) |-> trapIllegal);

  assert_time_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrWrite && csrAddr == ADDR_TIME) |-> trapIllegal);

endmodule

bind timer_compare_unit timer_compare_unit_chk #(
  .TIME_W(TIME_W), .ADDR_W(ADDR_W), .ADDR_SUP(ADDR_SUP),
  .ADDR_GUEST(ADDR_GUEST), .ADDR_TIME(ADDR_TIME)
) u_chk (.*);

// File: tb/timer_compare_unit_tb.sv
module timer_compare_unit_tb;

  localparam logic [11:0] A_SUP = 12'h14D;
  localparam logic [11:0] A_GST = 12'h24D;
  localparam logic [11:0] A_TIM = 12'hC01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [63:0] platformTime = 64'd100;
  logic [63:0] guestOffset = 64'd0;
  logic machTimerEn = 1'b1, hypTimerEn = 1'b1, cmpEnable = 1'b1;
  logic [1:0] priv = 2'b11;
  logic virt = 1'b0, csrValid = 1'b0, csrWrite = 1'b0;
  logic [11:0] csrAddr = 12'h0;
  logic [63:0] csrWdata = 64'h0;
  logic [63:0] csrRdata;
  logic trapIllegal, trapVirtual, supPending, guestPending;

  always #5 clk = ~clk;

  timer_compare_unit u_dut (.*);

  int checks = 0, fails = 0;
  string tag = "R4";

  logic [63:0] mSup = '1, mGuest = '1, mLocal = '0;
  logic [63:0] timeQ[$];

  // expected access outcome: 0 none, 1 sup, 2 guest, 3 time, 4 offset time
  task automatic expectAccess(output logic ill, output logic vir, output int tgt);
    bit guestCtx;
    guestCtx = virt && priv != 2'b11;
    ill = 0; vir = 0; tgt = 0;
    if (!csrValid) return;
    if (csrAddr == A_TIM) begin
      if (csrWrite) ill = 1;            // R11
      else tgt = guestCtx ? 4 : 3;      // R1, R11
    end else if (csrAddr == A_SUP) begin
      if (priv == 2'b11) tgt = 1;       // R8
      else if (priv != 2'b01) ill = 1;  // R13
      else if (!machTimerEn) ill = 1;   // R8
      else if (!cmpEnable) ill = 1;     // R10
      else if (virt && !hypTimerEn) ill = 1; // R9
      else tgt = virt ? 2 : 1;          // R6
    end else if (csrAddr == A_GST) begin
      if (guestCtx) vir = 1;            // R7
      else if (priv == 2'b11 || priv == 2'b01) tgt = 2;
      else ill = 1;                     // R13
    end
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    logic ill, vir; int tgt;
    logic [63:0] rd;
    expectAccess(ill, vir, tgt);
    case (tgt)
      1: rd = mSup;
      2: rd = mGuest;
      3: rd = mLocal;
      4: rd = mLocal + guestOffset;
      default: rd = '0;
    endcase
    chk("rdata", csrRdata, rd);
    chk("trapIllegal", {63'd0, trapIllegal}, {63'd0, ill});
    chk("trapVirtual", {63'd0, trapVirtual}, {63'd0, vir});
    chk("supPending (R2)", {63'd0, supPending}, {63'd0, mLocal >= mSup});
    chk("guestPending (R3)", {63'd0, guestPending},
        {63'd0, (mLocal + guestOffset) >= mGuest});
  endtask

  task automatic modelEdge();
    logic ill, vir; int tgt;
    expectAccess(ill, vir, tgt);
    if (csrWrite && tgt == 1) mSup = csrWdata;   // R5
    if (csrWrite && tgt == 2) mGuest = csrWdata;
    timeQ.push_back(platformTime);
    mLocal = timeQ.pop_front();
  endtask

  task automatic tick();
    @(negedge clk);
    checkAll();
    modelEdge();
    @(posedge clk);
    #1 platformTime = platformTime + 64'd1;
  endtask

  task automatic acc(logic [1:0] p, logic v, logic w, logic [11:0] a, logic [63:0] d);
    priv = p; virt = v; csrWrite = w; csrAddr = a; csrWdata = d; csrValid = 1'b1;
    tick();
    csrValid = 1'b0; csrWrite = 1'b0; virt = 1'b0; priv = 2'b11;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    timeQ.push_back(64'd0);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tag = "R4"; tick(); tick();
    tag = "R1"; acc(2'b11, 0, 0, A_TIM, 0); repeat (4) tick(); acc(2'b11, 0, 0, A_TIM, 0);
    platformTime = 64'd5000; acc(2'b11, 0, 0, A_TIM, 0); tick(); acc(2'b11, 0, 0, A_TIM, 0);
    tag = "R2"; acc(2'b11, 0, 1, A_SUP, 64'd5008); repeat (8) tick();
    acc(2'b11, 0, 0, A_SUP, 0);
    tag = "R5"; acc(2'b11, 0, 1, A_SUP, 64'd0); tick();
    acc(2'b11, 0, 1, A_SUP, '1); tick();
    acc(2'b01, 0, 1, A_SUP, 64'd5030); repeat (3) tick();
    tag = "R3"; guestOffset = 64'hFFFF_FFFF_FFFF_FF00;
    acc(2'b11, 0, 1, A_GST, 64'd4790); repeat (6) tick();
    acc(2'b01, 0, 1, A_GST, '1); tick();
    tag = "R6"; acc(2'b01, 1, 1, A_SUP, 64'd4700); tick();
    acc(2'b01, 1, 0, A_SUP, 0); acc(2'b11, 0, 0, A_GST, 0); acc(2'b11, 0, 0, A_SUP, 0);
    tag = "R7"; acc(2'b01, 1, 1, A_GST, 64'd1); acc(2'b00, 1, 0, A_GST, 0);
    acc(2'b11, 0, 0, A_GST, 0);
    tag = "R8"; machTimerEn = 0;
    acc(2'b01, 0, 1, A_SUP, 64'd3); acc(2'b01, 1, 1, A_SUP, 64'd3);
    acc(2'b11, 0, 1, A_SUP, '1); acc(2'b11, 0, 0, A_SUP, 0); machTimerEn = 1;
    tag = "R9"; hypTimerEn = 0; acc(2'b01, 1, 1, A_SUP, 64'd7);
    acc(2'b01, 0, 0, A_SUP, 0); hypTimerEn = 1; acc(2'b11, 0, 0, A_GST, 0);
    tag = "R10"; cmpEnable = 0; acc(2'b01, 0, 1, A_SUP, 64'd9);
    acc(2'b01, 1, 0, A_SUP, 0); acc(2'b11, 0, 0, A_SUP, 0); cmpEnable = 1;
    tag = "R11"; acc(2'b11, 0, 1, A_TIM, 64'd1); acc(2'b01, 1, 0, A_TIM, 0);
    acc(2'b01, 0, 0, A_TIM, 0);
    tag = "R12"; acc(2'b10, 0, 1, A_SUP, 64'd2); acc(2'b11, 0, 0, A_SUP, 0);
    tag = "R13"; acc(2'b00, 0, 1, A_SUP, 64'd4); acc(2'b00, 0, 1, A_GST, 64'd4);
    acc(2'b11, 0, 0, A_SUP, 0); acc(2'b11, 0, 0, A_GST, 0);
    tag = "R2"; platformTime = 64'hFFFF_FFFF_FFFF_FFF0;
    acc(2'b11, 0, 1, A_SUP, 64'hFFFF_FFFF_FFFF_FFF4); repeat (8) tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule